// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit forms a physical address from a segment and an offset, in one of two modes chosen per request. In real mode a 16-bit segment value is scaled by sixteen and added to the low 16 bits of the offset, giving a 20-bit address. In protected mode a 32-bit base, taken from a descriptor the caller has already cached, is added to a 32-bit offset without any shift. The offset is also compared against the cached 32-bit limit, and an out-of-range offset raises a fault.

Each request is presented for one cycle with `req_valid` high. One clock later the unit presents the address with either `addr_valid` or `addr_fault` set, never both. The unit does not fetch descriptors, check privilege or translate pages. Those jobs belong to the surrounding pipeline.

Top module: `seg_addr_gen`

## Requirements
- R1: In real mode (`mode_prot`=0) the result is `seg_sel`*16 + `offset[15:0]`, taken to 20 bits, with `phys_addr[31:20]` zero and `addr_valid`=1. For example, F000h with 052Dh gives 000F052Dh.
- R2: A real-mode sum that carries past bit 19 wraps modulo 2^20, so FFFFh:0010h gives 00000000h with `addr_valid`=1.
- R3: In real mode, `offset[31:16]`, `desc_base` and `desc_limit` have no effect on the result.
- R4: In protected mode (`mode_prot`=1) the result is `desc_base` + `offset` with no shift, and the base may have any alignment.
- R5: In protected mode, an offset greater than `desc_limit` sets `addr_fault`=1 and `addr_valid`=0, and forces `phys_addr` to 0.
- R6: The limit test is inclusive. An offset equal to `desc_limit` is legal.
- R7: In protected mode, a sum that carries out of bit 31 sets `addr_fault`=1 and forces `phys_addr` to 0.
- R8: The result appears on the clock edge after a request. In a cycle with no request, the next edge clears `addr_valid` and `addr_fault` and sets `phys_addr` to 0.
- R9: `addr_valid` and `addr_fault` are never high together.
- R10: During reset and until the first request, the outputs are `addr_valid`=0, `addr_fault`=0, `phys_addr`=0 and `res_prot`=0, meaning real mode.
- R11: `res_prot` shows the mode of the most recent request and holds that value through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| mode_prot | input | 1 | 0 = real mode, 1 = protected mode |
| seg_sel | input | 16 | Real-mode segment value |
| desc_base | input | 32 | Cached descriptor base (protected mode) |
| desc_limit | input | 32 | Cached descriptor limit, inclusive (protected mode) |
| offset | input | 32 | Offset; only bits 15:0 are used in real mode |
| phys_addr | output | 32 | Formed address, 0 on fault or when idle |
| addr_valid | output | 1 | Address is legal |
| addr_fault | output | 1 | Request broke the limit or overflowed |
| res_prot | output | 1 | Mode of the latest request |

## Verification
The assertions assume `req_valid` is low while reset is held. They also assume that the inputs which go with a request are stable at the clock edge that samples them, because each property compares an output with the inputs of the cycle before. The bench applies all inputs on the falling edge and holds `req_valid` low throughout reset. The random stimulus picks offsets close to the limit and bases close to the top of the 32-bit range, so that the limit and carry properties are triggered often and not just by chance.

// File: rtl/agu_pkg.sv
// Package: shared mode encoding and result flag type for the address unit.
// Assumes: mode bit 0 selects real mode, 1 selects protected mode.
package agu_pkg;
    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } agu_mode_e;

    typedef struct packed {
        logic valid;
        logic fault;
    } agu_flags_t;
endpackage

// File: rtl/agu_real_sum.sv
// Real-mode adder: scales the segment by 2^SHIFT and adds the offset.
// Assumes: OFF_W <= AW; the carry out of AW bits is dropped (wraps).
module agu_real_sum #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int AW    = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [AW-1:0]    sum
);
    logic [AW-1:0] seg_scaled;

    // Shift segment and add offset, keeping AW bits only.
    always_comb begin
        seg_scaled = AW'(seg) << SHIFT;
        sum        = seg_scaled + AW'(off);
    end
endmodule

// File: rtl/agu_prot_sum.sv
// Protected-mode adder: base plus offset, with limit and carry checks.
// Assumes: limit is inclusive; a carry out of the top bit is a fault.
module agu_prot_sum #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] off,
    output logic [AW-1:0] sum,
    output logic          fault
);
    logic [AW:0] wide;
    logic        over_limit;

    // Sum with carry kept, then fold limit and carry into one fault.
    always_comb begin
        wide       = {1'b0, base} + {1'b0, off};
        over_limit = (off > limit);
        sum        = wide[AW-1:0];
        fault      = wide[AW] | over_limit;
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Top: selects real or protected address formation per request and
// registers the result with one cycle of latency.
// Assumes: request inputs are stable at the sampling edge; reset is
// synchronous and active low.
module seg_addr_gen #(
    parameter int SEG_W     = 16,
    parameter int REAL_OFFW = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 mode_prot,
    input  logic [SEG_W-1:0]     seg_sel,
    input  logic [PA_W-1:0]      desc_base,
    input  logic [PA_W-1:0]      desc_limit,
    input  logic [PA_W-1:0]      offset,
    output logic [PA_W-1:0]      phys_addr,
    output logic                 addr_valid,
    output logic                 addr_fault,
    output logic                 res_prot
);
    import agu_pkg::*;

    localparam int REAL_AW = SEG_W + SEG_SHIFT;

    logic [REAL_AW-1:0] real_sum;
    logic [PA_W-1:0]    prot_sum;
    logic               prot_fault;
    agu_mode_e          req_mode;
    agu_flags_t         nxt_flags;
    logic [PA_W-1:0]    nxt_addr;

    agu_real_sum #(
        .SEG_W (SEG_W),
        .OFF_W (REAL_OFFW),
        .SHIFT (SEG_SHIFT),
        .AW    (REAL_AW)
    ) u_real (
        .seg (seg_sel),
        .off (offset[REAL_OFFW-1:0]),
        .sum (real_sum)
    );

    agu_prot_sum #(
        .AW (PA_W)
    ) u_prot (
        .base  (desc_base),
        .limit (desc_limit),
        .off   (offset),
        .sum   (prot_sum),
        .fault (prot_fault)
    );

    // Pick the path for this request and build next-cycle outputs.
    always_comb begin
        req_mode  = agu_mode_e'(mode_prot);
        nxt_flags = '0;
        nxt_addr  = '0;
        if (req_valid) begin
            if (req_mode == MODE_PROT) begin
                nxt_flags.fault = prot_fault;
                nxt_flags.valid = ~prot_fault;
                nxt_addr        = prot_fault ? '0 : prot_sum;
            end else begin
                nxt_flags.valid = 1'b1;
                nxt_addr        = {{(PA_W-REAL_AW){1'b0}}, real_sum};
            end
        end
    end

    // Output register stage; mode flag held between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr  <= '0;
            addr_valid <= 1'b0;
            addr_fault <= 1'b0;
            res_prot   <= 1'b0;
        end else begin
            phys_addr  <= nxt_addr;
            addr_valid <= nxt_flags.valid;
            addr_fault <= nxt_flags.fault;
            if (req_valid) begin
                res_prot <= (req_mode == MODE_PROT);
            end
        end
    end
endmodule

// File: rtl/seg_addr_gen_chk.sv
// Checker: temporal properties of the address unit, bound to the top.
// Assumes: req_valid is low while reset is held.
module seg_addr_gen_chk #(
    parameter int SEG_W     = 16,
    parameter int REAL_OFFW = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             mode_prot,
    input logic [SEG_W-1:0] seg_sel,
    input logic [PA_W-1:0]  desc_base,
    input logic [PA_W-1:0]  desc_limit,
    input logic [PA_W-1:0]  offset,
    input logic [PA_W-1:0]  phys_addr,
    input logic             addr_valid,
    input logic             addr_fault,
    input logic             res_prot
);
    localparam int REAL_AW = SEG_W + SEG_SHIFT;

    logic [PA_W:0] wide_sum;
    assign wide_sum = {1'b0, desc_base} + {1'b0, offset};

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && addr_fault));

    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && !addr_fault && phys_addr == '0));

    assert_real_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_prot) |=> (addr_valid && (phys_addr >> REAL_AW) == '0));

    assert_over_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_prot && offset > desc_limit) |=> (addr_fault && phys_addr == '0));

    assert_carry_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_prot && wide_sum[PA_W]) |=> addr_fault);

    assert_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_prot && offset == desc_limit && !wide_sum[PA_W]) |=> addr_valid);

    assert_prot_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_prot && offset <= desc_limit && !wide_sum[PA_W])
        |=> (phys_addr == $past(wide_sum[PA_W-1:0])));

    assert_mode_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_prot == $past(mode_prot)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
    .SEG_W     (SEG_W),
    .REAL_OFFW (REAL_OFFW),
    .SEG_SHIFT (SEG_SHIFT),
    .PA_W      (PA_W)
) u_chk (.*);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random requests, checked against
// expected values computed here from the requirements.
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        mode_prot = 1'b0;
    logic [15:0] seg_sel = '0;
    logic [31:0] desc_base = '0;
    logic [31:0] desc_limit = '0;
    logic [31:0] offset = '0;
    logic [31:0] phys_addr;
    logic        addr_valid;
    logic        addr_fault;
    logic        res_prot;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    seg_addr_gen u0 (
        .clk, .rst_n, .req_valid, .mode_prot, .seg_sel, .desc_base,
        .desc_limit, .offset, .phys_addr, .addr_valid, .addr_fault, .res_prot
    );

    always #5 clk = ~clk;

    // Compare all outputs against expectations, one line per failure.
    task automatic chk(string rq, logic [31:0] ea, logic ev, logic ef, logic em);
        n_chk++;
        if (phys_addr !== ea || addr_valid !== ev || addr_fault !== ef || res_prot !== em) begin
            n_bad++;
            $display("FAIL %s: got addr=%h v=%b f=%b m=%b exp addr=%h v=%b f=%b m=%b",
                     rq, phys_addr, addr_valid, addr_fault, res_prot, ea, ev, ef, em);
        end
    endtask

    // Model of real-mode formation (R1, R2).
    function automatic logic [31:0] real_exp(logic [15:0] s, logic [31:0] o);
        logic [19:0] r;
        r = {s, 4'h0} + {4'h0, o[15:0]};
        return {12'h0, r};
    endfunction

    // Issue one request and check the result one edge later.
    task automatic req(string rq, logic m, logic [15:0] s, logic [31:0] b,
                       logic [31:0] l, logic [31:0] o);
        logic [32:0] w;
        logic        f;
        logic [31:0] ea;
        @(negedge clk);
        req_valid = 1'b1; mode_prot = m; seg_sel = s;
        desc_base = b; desc_limit = l; offset = o;
        if (m) begin
            w  = {1'b0, b} + {1'b0, o};
            f  = w[32] | (o > l);
            ea = f ? 32'h0 : w[31:0];
        end else begin
            f  = 1'b0;
            ea = real_exp(s, o);
        end
        @(posedge clk);
        #1;
        chk(rq, ea, ~f, f, m);
    endtask

    // One idle cycle; the outputs clear and the mode flag holds.
    task automatic idle(string rq, logic em);
        @(negedge clk);
        req_valid = 1'b0;
        offset = 32'hDEAD_BEEF;
        @(posedge clk);
        #1;
        chk(rq, 32'h0, 1'b0, 1'b0, em);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset", 32'h0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 after reset", 32'h0, 1'b0, 1'b0, 1'b0);

        req("R1 example", 1'b0, 16'hF000, 32'h0, 32'h0, 32'h0000_052D);
        req("R1 zero", 1'b0, 16'h0000, 32'h0, 32'h0, 32'h0000_0000);
        req("R2 wrap", 1'b0, 16'hFFFF, 32'h0, 32'h0, 32'h0000_0010);
        req("R2 max", 1'b0, 16'hFFFF, 32'h0, 32'h0, 32'h0000_FFFF);
        req("R3 junk upper", 1'b0, 16'h1234, 32'hFFFF_FFFF, 32'h0, 32'hABCD_0042);
        req("R4 unaligned", 1'b1, 16'h0, 32'h0001_2347, 32'hFFFF_FFFF, 32'h0000_1001);
        idle("R11 hold prot", 1'b1);
        idle("R8 idle", 1'b1);
        req("R6 at limit", 1'b1, 16'h0, 32'h0010_0000, 32'h0000_0FFF, 32'h0000_0FFF);
        req("R5 limit+1", 1'b1, 16'h0, 32'h0010_0000, 32'h0000_0FFF, 32'h0000_1000);
        req("R7 carry", 1'b1, 16'h0, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h0000_0010);
        req("R7 no carry", 1'b1, 16'h0, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h0000_000F);
        req("R11 back real", 1'b0, 16'h0ABC, 32'h5, 32'h0, 32'h0000_0001);
        idle("R11 hold real", 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic        m;
            logic [31:0] b, l, o;
            m = 1'($urandom);
            b = $urandom;
            if ($urandom_range(0, 3) == 0) b = 32'hFFFF_0000 | 32'($urandom_range(0, 65535));
            l = $urandom;
            case ($urandom_range(0, 3))
                0: o = l;
                1: o = l + 1;
                2: o = l - 32'($urandom_range(0, 15));
                default: o = $urandom;
            endcase
            req(m ? "R4 R5 R7 random prot" : "R1 R3 random real", m, 16'($urandom), b, l, o);
            if ($urandom_range(0, 7) == 0) idle("R8 random idle", m);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule